// File: doc/BRIEF.md
# Watermarked Stream Buffer with Loss Accounting

This block sits between a sample producer and an export path. Words enter with a sequence number and a flag that marks them as part of a triggered capture window. They leave in arrival order through a valid/ready port. Three programmable occupancy thresholds raise level flags as the buffer fills. A throttle output asks the producer to pause once the upper threshold is reached and releases it only after occupancy has fallen below the middle threshold.

When the buffer is full, the block decides what to sacrifice. Background words are given up first, either by refusing a new background word or by evicting the oldest stored background word to make room for a protected one. Triggered words and gap markers are protected. A protected word is refused only when every stored word is itself protected. Every loss is counted and latched into a sticky flag.

A break in the input sequence numbering is counted. It also places a marker word into the stream just ahead of the word that revealed the break, so that the consumer can see the hole in band. Pulse inputs from the link side feed a CRC-error counter and a retry counter. Every counter saturates. The counters, the peak-occupancy record and the loss flag are cleared through a write-one-to-clear strobe.

Top module: `wm_stream_fifo`

## Requirements
- R1: Words leave in arrival order. `out_valid` is high exactly when `occupancy` is non-zero, and the `out_*` fields show the oldest stored word. A word is removed when `out_valid` and `out_ready` are both high at a clock edge. That removal takes effect before the same cycle's insertions, and occupancy never exceeds DEPTH.
- R2: `lvl_low`, `lvl_mid` and `lvl_high` are high when `occupancy` is greater than or equal to `wm_low`, `wm_mid` and `wm_high` respectively.
- R3: After an edge, `throttle` is 1 if the new occupancy is at least `wm_high`. It is 0 if the new occupancy is below `wm_mid`. Otherwise it keeps its previous value.
- R4: A protected word arriving at a full buffer removes the oldest stored background word and is appended at the tail. Each eviction adds 1 to `drop_count`. A protected word is one with `out_trig`=1 or `out_marker`=1.
- R5: A background word (`in_trig`=0) arriving at a full buffer is discarded and adds 1 to `drop_count`.
- R6: A protected word arriving at a full buffer that holds no background word is discarded and adds 1 to `prio_drop_count`.
- R7: After the first accepted word since reset, an accepted word whose sequence number differs from the previous number plus one (modulo 2^SEQ_W) adds 1 to `gap_count`. It is also preceded in the buffer by a marker word with `out_marker`=1, `out_seq` equal to the expected number, and `out_data` equal to (received − expected) mod 2^SEQ_W, zero-extended.
- R8: `drop_flag` becomes 1 on the edge of any loss (R4, R5 or R6). It stays 1 until cleared, and a loss in the clearing cycle wins.
- R9: Each of the five counters stops at all ones instead of wrapping. Every `crc_err_pulse` or `retry_pulse` cycle adds 1 to `crc_count` or `retry_count`.
- R10: When `clr_we` is high, each set bit of `clr_bits` clears one item: bit 0 gap, bit 1 drop, bit 2 priority drop, bit 3 CRC, bit 4 retry, bit 5 peak, bit 6 loss flag. An increment that falls in the clearing cycle is kept, so the counter restarts from that increment.
- R11: `peak_occ` holds the largest occupancy seen since reset or since its last clear. On a clear it takes the new occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_trig | input | 1 | Input word belongs to a triggered window |
| in_seq | input | SEQ_W | Input sequence number |
| in_data | input | DATA_W | Input payload |
| throttle | output | 1 | Backpressure request to the producer |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output payload, or gap length for a marker |
| out_seq | output | SEQ_W | Output sequence number, or first missing number for a marker |
| out_trig | output | 1 | Output word is triggered data |
| out_marker | output | 1 | Output word is a gap marker |
| wm_low | input | CW | Low occupancy threshold |
| wm_mid | input | CW | Middle threshold, also the throttle release level |
| wm_high | input | CW | High threshold, also the throttle set level |
| lvl_low | output | 1 | Occupancy at or above low threshold |
| lvl_mid | output | 1 | Occupancy at or above middle threshold |
| lvl_high | output | 1 | Occupancy at or above high threshold |
| occupancy | output | CW | Stored word count |
| peak_occ | output | CW | Highest occupancy recorded |
| crc_err_pulse | input | 1 | One CRC error event |
| retry_pulse | input | 1 | One retry event |
| clr_we | input | 1 | Clear strobe |
| clr_bits | input | 7 | Write-one-to-clear selection |
| gap_count | output | CNT_W | Sequence gaps seen |
| drop_count | output | CNT_W | Background words lost |
| prio_drop_count | output | CNT_W | Protected words lost |
| crc_count | output | CNT_W | CRC error events |
| retry_count | output | CNT_W | Retry events |
| drop_flag | output | 1 | Sticky loss indication |

## Verification
The assertions check several rules on every cycle. Occupancy stays bounded and grows by at most two words per edge. A protected head word is held while the consumer stalls. Throttle only rises at or above the high threshold and only falls below the middle one. The loss flag is sticky, a saturated CRC counter stays saturated, and the peak never trails the current occupancy. Only the bench's scenarios can show which word is evicted, the exact marker contents, the counter values after mixed drops and clears, and full ordering of the stream. The bench compares these against an arithmetic queue model over directed fill, eviction and gap sequences and over long random traffic under several threshold settings.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

    parameter int DATA_W = 16;
    parameter int SEQ_W  = 8;

    localparam int NUM_CNT  = 5;
    localparam int CI_GAP   = 0;
    localparam int CI_BG    = 1;
    localparam int CI_PRIO  = 2;
    localparam int CI_CRC   = 3;
    localparam int CI_RETRY = 4;
    localparam int CLR_PEAK = 5;
    localparam int CLR_FLAG = 6;
    localparam int CLR_W    = 7;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  marker;
        logic  trig;
        seq_t  seq;
        data_t data;
    } word_t;

    // Protected words survive congestion ahead of background data.
    function automatic logic is_kept(word_t w);
        return w.marker | w.trig;
    endfunction

    function automatic word_t make_marker(seq_t expected, seq_t received);
        word_t m;
        seq_t  span;
        span     = received - expected;
        m.marker = 1'b1;
        m.trig   = 1'b0;
        m.seq    = expected;
        m.data   = data_t'(span);
        return m;
    endfunction

endpackage

// File: rtl/wsf_seq_track.sv
module wsf_seq_track
    import wsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  seq_t in_seq,
    output logic gap,
    output seq_t expect_seq
);

    logic seen_q;
    seq_t exp_q;

    assign gap        = in_valid && seen_q && (in_seq != exp_q);
    assign expect_seq = exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            exp_q  <= '0;
        end else if (in_valid) begin
            seen_q <= 1'b1;
            exp_q  <= in_seq + seq_t'(1);
        end
    end

endmodule

// File: rtl/wsf_store.sv
module wsf_store
    import wsf_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          a_valid,
    input  word_t         a_word,
    input  logic          b_valid,
    input  word_t         b_word,
    output word_t         head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx,
    output logic [1:0]    evict_n,
    output logic [1:0]    bg_drop_n,
    output logic [1:0]    prio_drop_n
);

    word_t         mem  [DEPTH];
    word_t         work [DEPTH];
    logic          pv   [2];
    word_t         pw   [2];
    logic [CW-1:0] fill;
    logic          found;
    int            victim;

    always_comb begin
        pv[0] = a_valid;
        pw[0] = a_word;
        pv[1] = b_valid;
        pw[1] = b_word;
        for (int i = 0; i < DEPTH; i++) work[i] = mem[i];
        fill        = count;
        evict_n     = '0;
        bg_drop_n   = '0;
        prio_drop_n = '0;
        found       = 1'b0;
        victim      = 0;

        // Removal first, so the freed slot serves this cycle's arrivals.
        if (pop && count != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) work[i] = work[i+1];
            fill = fill - CW'(1);
        end

        for (int s = 0; s < 2; s++) begin
            if (pv[s]) begin
                if (fill < CW'(DEPTH)) begin
                    work[fill[AW-1:0]] = pw[s];
                    fill = fill + CW'(1);
                end else if (is_kept(pw[s])) begin
                    found  = 1'b0;
                    victim = 0;
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!found && !is_kept(work[i])) begin
                            found  = 1'b1;
                            victim = i;
                        end
                    end
                    if (found) begin
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            if (i >= victim) work[i] = work[i+1];
                        end
                        work[DEPTH-1] = pw[s];
                        evict_n = evict_n + 2'd1;
                    end else begin
                        prio_drop_n = prio_drop_n + 2'd1;
                    end
                end else begin
                    bg_drop_n = bg_drop_n + 2'd1;
                end
            end
        end
    end

    assign head     = mem[0];
    assign count_nx = fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            count <= fill;
            for (int i = 0; i < DEPTH; i++) mem[i] <= work[i];
        end
    end

endmodule

// File: rtl/wsf_stat_bank.sv
module wsf_stat_bank #(
    parameter int N = 5,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0][1:0]   inc,
    input  logic [N-1:0]        clr,
    output logic [N-1:0][W-1:0] value
);

    localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] cnt_q;
        logic [W:0]   base;
        logic [W:0]   sum;

        always_comb begin
            base = clr[g] ? '0 : {1'b0, cnt_q};
            sum  = base + {{(W - 1){1'b0}}, inc[g]};
        end

        always_ff @(posedge clk) begin
            if (rst)            cnt_q <= '0;
            else if (sum > TOP) cnt_q <= TOP[W-1:0];
            else                cnt_q <= sum[W-1:0];
        end

        assign value[g] = cnt_q;
    end

endmodule

// File: rtl/wm_stream_fifo.sv
module wm_stream_fifo
    import wsf_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int CNT_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_trig,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [DATA_W-1:0] in_data,
    output logic              throttle,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [SEQ_W-1:0]  out_seq,
    output logic              out_trig,
    output logic              out_marker,
    input  logic [CW-1:0]     wm_low,
    input  logic [CW-1:0]     wm_mid,
    input  logic [CW-1:0]     wm_high,
    output logic              lvl_low,
    output logic              lvl_mid,
    output logic              lvl_high,
    output logic [CW-1:0]     occupancy,
    output logic [CW-1:0]     peak_occ,
    input  logic              crc_err_pulse,
    input  logic              retry_pulse,
    input  logic              clr_we,
    input  logic [6:0]        clr_bits,
    output logic [CNT_W-1:0]  gap_count,
    output logic [CNT_W-1:0]  drop_count,
    output logic [CNT_W-1:0]  prio_drop_count,
    output logic [CNT_W-1:0]  crc_count,
    output logic [CNT_W-1:0]  retry_count,
    output logic              drop_flag
);

    logic                        gap;
    seq_t                        expect_seq;
    word_t                       marker_w;
    word_t                       data_w;
    word_t                       head;
    logic [CW-1:0]               count_nx;
    logic [1:0]                  evict_n;
    logic [1:0]                  bg_drop_n;
    logic [1:0]                  prio_drop_n;
    logic                        pop;
    logic [CLR_W-1:0]            clr_sel;
    logic [NUM_CNT-1:0][1:0]     stat_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] stat_val;
    logic                        loss;

    wsf_seq_track i_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_seq     (in_seq),
        .gap        (gap),
        .expect_seq (expect_seq)
    );

    assign marker_w = make_marker(expect_seq, in_seq);
    assign data_w   = '{marker: 1'b0, trig: in_trig, seq: in_seq, data: in_data};

    assign out_valid = (occupancy != '0);
    assign pop       = out_valid && out_ready;

    wsf_store #(.DEPTH(DEPTH)) i_store (
        .clk         (clk),
        .rst         (rst),
        .pop         (pop),
        .a_valid     (gap),
        .a_word      (marker_w),
        .b_valid     (in_valid),
        .b_word      (data_w),
        .head        (head),
        .count       (occupancy),
        .count_nx    (count_nx),
        .evict_n     (evict_n),
        .bg_drop_n   (bg_drop_n),
        .prio_drop_n (prio_drop_n)
    );

    assign out_data   = head.data;
    assign out_seq    = head.seq;
    assign out_trig   = head.trig;
    assign out_marker = head.marker;

    assign lvl_low  = (occupancy >= wm_low);
    assign lvl_mid  = (occupancy >= wm_mid);
    assign lvl_high = (occupancy >= wm_high);

    assign clr_sel = clr_we ? clr_bits : '0;

    always_comb begin
        stat_inc           = '0;
        stat_inc[CI_GAP]   = {1'b0, gap};
        stat_inc[CI_BG]    = evict_n + bg_drop_n;
        stat_inc[CI_PRIO]  = prio_drop_n;
        stat_inc[CI_CRC]   = {1'b0, crc_err_pulse};
        stat_inc[CI_RETRY] = {1'b0, retry_pulse};
    end

    wsf_stat_bank #(.N(NUM_CNT), .W(CNT_W)) i_stats (
        .clk   (clk),
        .rst   (rst),
        .inc   (stat_inc),
        .clr   (clr_sel[NUM_CNT-1:0]),
        .value (stat_val)
    );

    assign gap_count       = stat_val[CI_GAP];
    assign drop_count      = stat_val[CI_BG];
    assign prio_drop_count = stat_val[CI_PRIO];
    assign crc_count       = stat_val[CI_CRC];
    assign retry_count     = stat_val[CI_RETRY];

    assign loss = (evict_n != '0) || (bg_drop_n != '0) || (prio_drop_n != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            throttle  <= 1'b0;
            peak_occ  <= '0;
            drop_flag <= 1'b0;
        end else begin
            if (count_nx >= wm_high)    throttle <= 1'b1;
            else if (count_nx < wm_mid) throttle <= 1'b0;

            if (clr_sel[CLR_PEAK] || count_nx > peak_occ) peak_occ <= count_nx;

            drop_flag <= loss | (drop_flag & ~clr_sel[CLR_FLAG]);
        end
    end

endmodule

// File: rtl/wsf_checker.sv
module wsf_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 8,
    parameter int SEQ_W = 8,
    parameter int DATA_W = 16,
    parameter int CW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_trig,
    input logic              out_marker,
    input logic [DATA_W-1:0] out_data,
    input logic [SEQ_W-1:0]  out_seq,
    input logic              throttle,
    input logic [CW-1:0]     occupancy,
    input logic [CW-1:0]     peak_occ,
    input logic [CW-1:0]     wm_mid,
    input logic [CW-1:0]     wm_high,
    input logic              drop_flag,
    input logic              clr_we,
    input logic [6:0]        clr_bits,
    input logic [CNT_W-1:0]  crc_count
);

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(occupancy) <= DEPTH);

    // R1
    occ_step_chk: assert property (@(posedge clk) disable iff (rst)
        int'(occupancy) <= int'($past(occupancy)) + 2);

    // R1
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && (out_trig || out_marker)
        |=> out_valid && $stable(out_seq) && $stable(out_data));

    // R3
    thr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(throttle) && $stable(wm_high) |-> occupancy >= wm_high);

    // R3
    thr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(throttle) && $stable(wm_mid) |-> occupancy < wm_mid);

    // R3
    thr_high_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy >= wm_high && $stable(wm_high) |-> throttle);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        drop_flag && !(clr_we && clr_bits[6]) |=> drop_flag);

    // R9
    crc_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (&crc_count) && !(clr_we && clr_bits[3]) |=> (&crc_count));

    // R11
    peak_floor_chk: assert property (@(posedge clk) disable iff (rst)
        peak_occ >= occupancy);

endmodule

bind wm_stream_fifo wsf_checker #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .SEQ_W(wsf_pkg::SEQ_W),
    .DATA_W(wsf_pkg::DATA_W), .CW(CW)
) i_wsf_checker (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_trig   (out_trig),
    .out_marker (out_marker),
    .out_data   (out_data),
    .out_seq    (out_seq),
    .throttle   (throttle),
    .occupancy  (occupancy),
    .peak_occ   (peak_occ),
    .wm_mid     (wm_mid),
    .wm_high    (wm_high),
    .drop_flag  (drop_flag),
    .clr_we     (clr_we),
    .clr_bits   (clr_bits),
    .crc_count  (crc_count)
);

// File: tb/test_wm_stream_fifo.sv
module test_wm_stream_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int CNT_W      = 4;
    localparam int CMAX       = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_trig, out_ready;
    logic [7:0]  in_seq;
    logic [15:0] in_data;
    logic        throttle, out_valid, out_trig, out_marker;
    logic [15:0] out_data;
    logic [7:0]  out_seq;
    logic [3:0]  wm_low, wm_mid, wm_high, occupancy, peak_occ;
    logic        lvl_low, lvl_mid, lvl_high;
    logic        crc_err_pulse, retry_pulse, clr_we;
    logic [6:0]  clr_bits;
    logic [3:0]  gap_count, drop_count, prio_drop_count, crc_count, retry_count;
    logic        drop_flag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wm_stream_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_wm_stream_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_trig(in_trig),
        .in_seq(in_seq), .in_data(in_data), .throttle(throttle),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_seq(out_seq), .out_trig(out_trig), .out_marker(out_marker),
        .wm_low(wm_low), .wm_mid(wm_mid), .wm_high(wm_high),
        .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high),
        .occupancy(occupancy), .peak_occ(peak_occ),
        .crc_err_pulse(crc_err_pulse), .retry_pulse(retry_pulse),
        .clr_we(clr_we), .clr_bits(clr_bits),
        .gap_count(gap_count), .drop_count(drop_count),
        .prio_drop_count(prio_drop_count), .crc_count(crc_count),
        .retry_count(retry_count), .drop_flag(drop_flag)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    typedef struct {
        bit        mk;
        bit        tr;
        bit [7:0]  sq;
        bit [15:0] dt;
    } ment_t;

    ment_t    q[$];
    int       m_gap, m_bg, m_pr, m_crc, m_rty, m_peak;
    bit       m_flag, m_thr, m_seen;
    bit [7:0] m_exp;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic void m_insert(ment_t e, inout int bg, inout int pr);
        int idx;
        if (q.size() < DEPTH) begin
            q.push_back(e);
        end else if (e.mk || e.tr) begin
            idx = -1;
            foreach (q[i]) if (idx < 0 && !q[i].mk && !q[i].tr) idx = i;
            if (idx >= 0) begin
                q.delete(idx);
                q.push_back(e);
                bg++;
            end else begin
                pr++;
            end
        end else begin
            bg++;
        end
    endfunction

    // Requirement model: advance one edge using the inputs now applied.
    function automatic void model_step();
        int       dbg = 0;
        int       dpr = 0;
        int       dgap = 0;
        int       occ;
        bit [7:0] span;
        ment_t    e;
        bit [6:0] c;
        c = clr_we ? clr_bits : 7'd0;
        if (out_ready && q.size() > 0) void'(q.pop_front());
        if (in_valid) begin
            if (m_seen && in_seq != m_exp) begin
                dgap = 1;
                span = in_seq - m_exp;
                e = '{mk: 1'b1, tr: 1'b0, sq: m_exp, dt: {8'd0, span}};
                m_insert(e, dbg, dpr);
            end
            e = '{mk: 1'b0, tr: in_trig, sq: in_seq, dt: in_data};
            m_insert(e, dbg, dpr);
            m_seen = 1'b1;
            m_exp  = in_seq + 8'd1;
        end
        occ = q.size();
        if (occ >= int'(wm_high))     m_thr = 1'b1;
        else if (occ < int'(wm_mid))  m_thr = 1'b0;
        m_gap = sat((c[0] ? 0 : m_gap) + dgap);
        m_bg  = sat((c[1] ? 0 : m_bg) + dbg);
        m_pr  = sat((c[2] ? 0 : m_pr) + dpr);
        m_crc = sat((c[3] ? 0 : m_crc) + int'(crc_err_pulse));
        m_rty = sat((c[4] ? 0 : m_rty) + int'(retry_pulse));
        if (c[5] || occ > m_peak) m_peak = occ;
        m_flag = (dbg + dpr > 0) || (m_flag && !c[6]);
    endfunction

    task automatic compare();
        int occ;
        occ = q.size();
        chk(int'(occupancy) == occ, "R1", "occupancy", occupancy, occ);
        chk(out_valid == (occ > 0), "R1", "out_valid", out_valid, occ > 0);
        if (occ > 0) begin
            chk(out_seq == q[0].sq, "R1", "out_seq", out_seq, q[0].sq);
            chk(out_data == q[0].dt, "R1", "out_data", out_data, q[0].dt);
            chk(out_trig == q[0].tr, "R1", "out_trig", out_trig, q[0].tr);
            chk(out_marker == q[0].mk, "R7", "out_marker", out_marker, q[0].mk);
        end
        chk(lvl_low == (occ >= int'(wm_low)), "R2", "lvl_low", lvl_low, occ >= int'(wm_low));
        chk(lvl_mid == (occ >= int'(wm_mid)), "R2", "lvl_mid", lvl_mid, occ >= int'(wm_mid));
        chk(lvl_high == (occ >= int'(wm_high)), "R2", "lvl_high", lvl_high, occ >= int'(wm_high));
        chk(throttle == m_thr, "R3", "throttle", throttle, m_thr);
        chk(int'(drop_count) == m_bg, "R4 R5", "drop_count", drop_count, m_bg);
        chk(int'(prio_drop_count) == m_pr, "R6", "prio_drop_count", prio_drop_count, m_pr);
        chk(int'(gap_count) == m_gap, "R7", "gap_count", gap_count, m_gap);
        chk(drop_flag == m_flag, "R8", "drop_flag", drop_flag, m_flag);
        chk(int'(crc_count) == m_crc, "R9", "crc_count", crc_count, m_crc);
        chk(int'(retry_count) == m_rty, "R9", "retry_count", retry_count, m_rty);
        chk(int'(peak_occ) == m_peak, "R11", "peak_occ", peak_occ, m_peak);
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic idle_inputs();
        in_valid = 0; in_trig = 0; in_seq = 0; in_data = 0;
        crc_err_pulse = 0; retry_pulse = 0; clr_we = 0; clr_bits = 0;
    endtask

    task automatic send(bit trig, bit [7:0] seq, bit rdy);
        in_valid = 1; in_trig = trig; in_seq = seq;
        in_data = {seq, ~seq}; out_ready = rdy;
        step();
        in_valid = 0; in_trig = 0;
    endtask

    task automatic drain();
        out_ready = 1;
        for (int i = 0; i < DEPTH + 1; i++) step();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        out_ready = 0;
        wm_low = 4'd2; wm_mid = 4'd4; wm_high = 4'd6;
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        q = {};
        m_gap = 0; m_bg = 0; m_pr = 0; m_crc = 0; m_rty = 0; m_peak = 0;
        m_flag = 0; m_thr = 0; m_seen = 0; m_exp = 0;
        compare(); // reset state, R1..R11 fields all at zero

        // Passthrough with a ready consumer (R1).
        for (int s = 0; s < 10; s++) send(1'b0, 8'(s), 1'b1);
        drain();

        // Fill with background while stalled: levels, throttle, drops (R2 R3 R5).
        for (int s = 10; s < 20; s++) send(1'b0, 8'(s), 1'b0);
        chk(drop_count == 4'd2, "R5", "bg drops on full", drop_count, 2);
        chk(throttle == 1'b1, "R3", "throttle when full", throttle, 1);

        // Triggered words evict oldest background (R4).
        for (int s = 20; s < 23; s++) send(1'b1, 8'(s), 1'b0);
        chk(drop_count == 4'd5, "R4", "evictions counted", drop_count, 5);
        chk(out_seq == 8'd13, "R4", "oldest bg evicted", out_seq, 13);
        for (int s = 23; s < 28; s++) send(1'b1, 8'(s), 1'b0);
        chk(out_trig == 1'b1, "R4", "head protected", out_trig, 1);
        send(1'b1, 8'd28, 1'b0);
        chk(prio_drop_count == 4'd1, "R6", "protected drop", prio_drop_count, 1);
        chk(drop_flag == 1'b1, "R8", "loss flag set", drop_flag, 1);

        // Release: throttle holds until below mid (R3).
        out_ready = 1;
        for (int i = 0; i < 3; i++) step();
        chk(throttle == 1'b1, "R3", "hysteresis hold at 5", throttle, 1);
        drain();
        chk(throttle == 1'b0, "R3", "released when empty", throttle, 0);

        // Gap marker (R7).
        send(1'b0, 8'd29, 1'b0);
        send(1'b0, 8'd33, 1'b0);
        out_ready = 1;
        step();
        out_ready = 0;
        step();
        chk(out_marker == 1'b1, "R7", "marker at head", out_marker, 1);
        chk(out_seq == 8'd30, "R7", "marker expected seq", out_seq, 30);
        chk(out_data == 16'd3, "R7", "marker span", out_data, 3);
        chk(gap_count == 4'd1, "R7", "gap counted", gap_count, 1);
        drain();

        // Saturation and write-one-to-clear (R9 R10).
        crc_err_pulse = 1; retry_pulse = 1;
        for (int i = 0; i < 20; i++) step();
        chk(crc_count == 4'hF, "R9", "crc saturates", crc_count, 15);
        clr_we = 1; clr_bits = 7'b0001000;
        step();
        chk(crc_count == 4'd1, "R10", "clear keeps increment", crc_count, 1);
        chk(retry_count == 4'hF, "R10", "unselected untouched", retry_count, 15);
        crc_err_pulse = 0; retry_pulse = 0;
        clr_bits = 7'b1111111;
        step();
        clr_we = 0; clr_bits = 0;
        chk(drop_flag == 1'b0, "R10", "flag cleared", drop_flag, 0);
        chk(peak_occ == occupancy, "R11", "peak reset to occupancy", peak_occ, occupancy);

        // Randomised traffic across threshold settings.
        for (int cfg = 0; cfg < 4; cfg++) begin
            wm_low  = 4'(cfg);
            wm_mid  = 4'(2 + cfg);
            wm_high = 4'(4 + cfg);
            for (int n = 0; n < 1500; n++) begin
                bit [7:0] nxt;
                int r;
                r = int'($urandom_range(0, 99));
                nxt = m_exp + ((r < 8) ? 8'($urandom_range(1, 5)) : 8'd0);
                in_valid = ($urandom_range(0, 3) != 0);
                in_trig = ($urandom_range(0, 3) == 0);
                in_seq = nxt;
                in_data = 16'($urandom);
                out_ready = ($urandom_range(0, 2) == 0) || (cfg == 3 && n > 1200);
                crc_err_pulse = ($urandom_range(0, 9) == 0);
                retry_pulse = ($urandom_range(0, 9) == 0);
                clr_we = ($urandom_range(0, 49) == 0);
                clr_bits = 7'($urandom);
                step();
            end
            idle_inputs();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule